// File: doc/BRIEF.md
# Sleep-Mode Power Sequencer

This block runs the low-power state of a small microcontroller. Software writes a sleep command, with a flag that picks a light tier (core clock off only) or a deep tier (core, UART and timer clocks off). The sequencer waits until the core has no memory access in flight. It then freezes the pipeline with a stall, removes the core clock enable one cycle later, and holds the chosen sleep state until a wake event arrives. The pipeline is never reset. Its contents and the memories are kept, because the memory enables stay high in every state.

Wake sources are an external GPIO interrupt, brought in through a synchronizer, and an on-chip timer wake pulse. The light tier accepts both. The deep tier accepts only the GPIO interrupt, because its timer clock is off. On wake, the clocks return for one cycle while the stall is still asserted, and then the stall drops in Run. A wake that arrives while the entry sequence is still running cancels the entry and goes straight back to Run. Outside deep sleep, the UART and timer clock enables follow each unit's activity. A UART with transmit data pending therefore keeps its clock in the light tier.

Top module: `pmu_sleep_ctrl`

## Requirements
- R1: Every bit of `mem_en_o` is 1 in every state and during reset.
- R2: In Run (`pstate_o`=0), `sleep_cmd_i`=1 moves the state to Drain (1) and latches `sleep_deep_i`. Drain persists while `mem_busy_i`=1 and no wake is present. Other encodings: Freeze=2, Idle=3, Deep=4, Wake=5.
- R3: `stall_o` is 1 in Freeze, Idle, Deep and Wake, and 0 in Run and Drain. Freeze lasts one cycle, with the core clock still enabled, before Idle or Deep.
- R4: `core_clk_en_o` is 1 in Run, Drain, Freeze and Wake, and 0 in Idle and Deep.
- R5: A wake (synchronized GPIO or `timer_wake_i`) seen in Drain or Freeze returns the state to Run on the next edge, with `stall_o`=0.
- R6: Idle leaves to Wake on a synchronized GPIO or on `timer_wake_i`. Wake lasts exactly one cycle, then Run follows.
- R7: Deep leaves only on a synchronized GPIO interrupt. `timer_wake_i` has no effect in Deep.
- R8: `gpio_irq_i` passes through SYNC_STAGES flops. If it rises before edge 1 while the state is Idle, the state becomes Wake at edge SYNC_STAGES+1.
- R9: `uart_clk_en_o` equals `uart_busy_i` in every state except Deep, where it is 0.
- R10: `timer_clk_en_o` equals `timer_busy_i` in every state except Deep, where it is 0.
- R11: `gpio_clk_en_o` is 1 in every state.
- R12: `sleep_cmd_i` has no effect outside Run.
- R13: After reset the state is Run, `stall_o`=0 and `core_clk_en_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_cmd_i | input | 1 | Software sleep command strobe |
| sleep_deep_i | input | 1 | Tier select with the command: 1 deep, 0 light |
| mem_busy_i | input | 1 | Core has a memory access outstanding |
| gpio_irq_i | input | 1 | Asynchronous GPIO interrupt level |
| timer_wake_i | input | 1 | Timer wake event |
| uart_busy_i | input | 1 | UART active or transmit buffer non-empty |
| timer_busy_i | input | 1 | Timer running |
| core_clk_en_o | output | 1 | Core pipeline clock enable |
| stall_o | output | 1 | Pipeline freeze |
| uart_clk_en_o | output | 1 | UART clock enable |
| timer_clk_en_o | output | 1 | Timer clock enable |
| gpio_clk_en_o | output | 1 | GPIO wake logic clock enable |
| mem_en_o | output | N_MEM | Memory enables, one per memory |
| pstate_o | output | 3 | Current power state |

## Verification
The bench builds the block with SYNC_STAGES=3 and N_MEM=3. The defaults are 2 and 2, so a three-flop synchronizer and a three-bit memory-enable vector are exercised. A deeper synchronizer keeps the GPIO wake hidden for three edges. This widens the window in which a short GPIO pulse or a timer pulse can hit Drain or Freeze, and makes an off-by-one in the wake latency visible at the ports. Random stimulus mixes commands, memory busy, wake levels and activity. Every cycle is compared against a reference model.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_DRAIN  = 3'd1,
    PS_FREEZE = 3'd2,
    PS_IDLE   = 3'd3,
    PS_DEEP   = 3'd4,
    PS_WAKE   = 3'd5
  } pstate_e;
endpackage

// File: rtl/pmu_wake_sync.sv
module pmu_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  localparam int Last = STAGES - 1;

  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= async_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], async_i};
    end
  endgenerate

  assign sync_o = q[Last];
endmodule

// File: rtl/pmu_seq.sv
module pmu_seq
  import pmu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sleep_cmd_i,
  input  logic    sleep_deep_i,
  input  logic    mem_busy_i,
  input  logic    gpio_wake_i,
  input  logic    timer_wake_i,
  output pstate_e state_o
);
  pstate_e state_q, state_d;
  logic    deep_q, deep_d;
  logic    wake_any;

  assign wake_any = gpio_wake_i | timer_wake_i;

  always_comb begin
    state_d = state_q;
    deep_d  = deep_q;
    unique case (state_q)
      PS_RUN: if (sleep_cmd_i) begin
        state_d = PS_DRAIN;
        deep_d  = sleep_deep_i;
      end
      PS_DRAIN:  if (wake_any)         state_d = PS_RUN;
                 else if (!mem_busy_i) state_d = PS_FREEZE;
      PS_FREEZE: if (wake_any)         state_d = PS_RUN;
                 else                  state_d = deep_q ? PS_DEEP : PS_IDLE;
      PS_IDLE:   if (wake_any)         state_d = PS_WAKE;
      PS_DEEP:   if (gpio_wake_i)      state_d = PS_WAKE;  // timer domain is off
      PS_WAKE:                         state_d = PS_RUN;
      default:                         state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= PS_RUN;
      deep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      deep_q  <= deep_d;
    end

  assign state_o = state_q;

  a_r2_drain_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_DRAIN && mem_busy_i && !wake_any) |=> state_q == PS_DRAIN);
  a_r7_deep_timer_blind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_DEEP && !gpio_wake_i) |=> state_q == PS_DEEP);
  a_r6_wake_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PS_WAKE |=> state_q == PS_RUN);
  a_r12_cmd_outside_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_IDLE && !wake_any) |=> state_q == PS_IDLE);
endmodule

// File: rtl/pmu_gate.sv
module pmu_gate
  import pmu_pkg::*;
#(
  parameter int N_MEM = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pstate_e          state_i,
  input  logic             uart_busy_i,
  input  logic             timer_busy_i,
  output logic             core_clk_en_o,
  output logic             stall_o,
  output logic             uart_clk_en_o,
  output logic             timer_clk_en_o,
  output logic             gpio_clk_en_o,
  output logic [N_MEM-1:0] mem_en_o
);
  logic in_deep;

  assign in_deep = (state_i == PS_DEEP);

  always_comb begin
    core_clk_en_o = 1'b1;
    stall_o       = 1'b0;
    unique case (state_i)
      PS_RUN, PS_DRAIN: ;
      PS_FREEZE, PS_WAKE: stall_o = 1'b1;
      PS_IDLE, PS_DEEP: begin
        stall_o       = 1'b1;
        core_clk_en_o = 1'b0;
      end
      default: ;
    endcase
  end

  // activity-based gating; deep tier drops everything but GPIO
  assign uart_clk_en_o  = uart_busy_i  & ~in_deep;
  assign timer_clk_en_o = timer_busy_i & ~in_deep;
  assign gpio_clk_en_o  = 1'b1;

  generate
    for (genvar i = 0; i < N_MEM; i++) begin : g_mem
      assign mem_en_o[i] = 1'b1;
    end
  endgenerate

  a_r4_gated_core_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_clk_en_o |-> stall_o);
  a_r3_stall_before_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> core_clk_en_o);
  a_r6_clock_before_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> $past(core_clk_en_o));
endmodule

// File: rtl/pmu_sleep_ctrl.sv
module pmu_sleep_ctrl
  import pmu_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_MEM       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_cmd_i,
  input  logic             sleep_deep_i,
  input  logic             mem_busy_i,
  input  logic             gpio_irq_i,
  input  logic             timer_wake_i,
  input  logic             uart_busy_i,
  input  logic             timer_busy_i,
  output logic             core_clk_en_o,
  output logic             stall_o,
  output logic             uart_clk_en_o,
  output logic             timer_clk_en_o,
  output logic             gpio_clk_en_o,
  output logic [N_MEM-1:0] mem_en_o,
  output logic [2:0]       pstate_o
);
  logic    gpio_wake;
  pstate_e state;

  pmu_wake_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (gpio_irq_i),
    .sync_o  (gpio_wake)
  );

  pmu_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_cmd_i  (sleep_cmd_i),
    .sleep_deep_i (sleep_deep_i),
    .mem_busy_i   (mem_busy_i),
    .gpio_wake_i  (gpio_wake),
    .timer_wake_i (timer_wake_i),
    .state_o      (state)
  );

  pmu_gate #(.N_MEM(N_MEM)) i_gate (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .state_i        (state),
    .uart_busy_i    (uart_busy_i),
    .timer_busy_i   (timer_busy_i),
    .core_clk_en_o  (core_clk_en_o),
    .stall_o        (stall_o),
    .uart_clk_en_o  (uart_clk_en_o),
    .timer_clk_en_o (timer_clk_en_o),
    .gpio_clk_en_o  (gpio_clk_en_o),
    .mem_en_o       (mem_en_o)
  );

  assign pstate_o = state;

  a_r5_abort_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_o == 3'd2 && timer_wake_i) |=> (pstate_o == 3'd0 && !stall_o));
endmodule

// File: tb/test_pmu_sleep_ctrl.sv
module test_pmu_sleep_ctrl;
  localparam int SYNC = 3;
  localparam int NMEM = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_cmd_i = 0, sleep_deep_i = 0, mem_busy_i = 0, gpio_irq_i = 0;
  logic timer_wake_i = 0, uart_busy_i = 0, timer_busy_i = 0;
  logic core_clk_en_o, stall_o, uart_clk_en_o, timer_clk_en_o, gpio_clk_en_o;
  logic [NMEM-1:0] mem_en_o;
  logic [2:0] pstate_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  pmu_sleep_ctrl #(.SYNC_STAGES(SYNC), .N_MEM(NMEM)) i_pmu_sleep_ctrl (.*);

  int vecs = 0, errs = 0;
  logic [2:0] m_st = 3'd0;
  logic m_deep = 1'b0;
  logic [SYNC-1:0] m_q = '0;

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  function automatic logic f_deep(input logic [2:0] s); return s == 3'd4; endfunction
  function automatic logic f_stall(input logic [2:0] s); return s >= 3'd2 && s <= 3'd5; endfunction
  function automatic logic f_core(input logic [2:0] s); return !(s == 3'd3 || s == 3'd4); endfunction

  function automatic logic [2:0] f_next(input logic [2:0] s, input logic dp, input logic gw);
    logic w;
    w = gw | timer_wake_i;
    case (s)
      3'd0: return sleep_cmd_i ? 3'd1 : 3'd0;
      3'd1: return w ? 3'd0 : (!mem_busy_i ? 3'd2 : 3'd1);
      3'd2: return w ? 3'd0 : (dp ? 3'd4 : 3'd3);
      3'd3: return w ? 3'd5 : 3'd3;
      3'd4: return gw ? 3'd5 : 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  task automatic check_all();
    chk("R1",  "mem_en",   8'(mem_en_o), 8'({NMEM{1'b1}}));
    chk("R2",  "state",    8'(pstate_o), 8'(m_st));
    chk("R3",  "stall",    8'(stall_o), 8'(f_stall(m_st)));
    chk("R4",  "core_en",  8'(core_clk_en_o), 8'(f_core(m_st)));
    chk("R9",  "uart_en",  8'(uart_clk_en_o), 8'(uart_busy_i & ~f_deep(m_st)));
    chk("R10", "timer_en", 8'(timer_clk_en_o), 8'(timer_busy_i & ~f_deep(m_st)));
    chk("R11", "gpio_en",  8'(gpio_clk_en_o), 8'd1);
  endtask

  // called just after a negedge with inputs set; ends at the next negedge
  task automatic cyc();
    logic [2:0] nx;
    #1 check_all();
    @(posedge clk_i);
    nx = f_next(m_st, m_deep, m_q[SYNC-1]);
    if (m_st == 3'd0 && sleep_cmd_i) m_deep = sleep_deep_i;
    m_st = nx;
    m_q  = {m_q[SYNC-2:0], gpio_irq_i};
    @(negedge clk_i);
  endtask

  task automatic quiet(input int n);
    sleep_cmd_i = 0; timer_wake_i = 0; gpio_irq_i = 0; mem_busy_i = 0;
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(20 * 100000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1 chk("R1", "mem_en in reset", 8'(mem_en_o), 8'({NMEM{1'b1}}));
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R13 reset state
    chk("R13", "state", 8'(pstate_o), 8'd0);
    chk("R13", "stall", 8'(stall_o), 8'd0);
    chk("R13", "core_en", 8'(core_clk_en_o), 8'd1);

    // light tier, drain on busy memory
    sleep_cmd_i = 1; sleep_deep_i = 0; mem_busy_i = 1; cyc();
    chk("R2", "enter drain", 8'(pstate_o), 8'd1);
    sleep_cmd_i = 0; cyc(); cyc();
    chk("R2", "drain held", 8'(pstate_o), 8'd1);
    mem_busy_i = 0; cyc();
    chk("R3", "freeze stall", 8'({stall_o, core_clk_en_o}), 8'b11);
    cyc();
    chk("R4", "idle core off", 8'({pstate_o, core_clk_en_o}), 8'({3'd3, 1'b0}));
    sleep_cmd_i = 1; sleep_deep_i = 1; cyc();
    chk("R12", "cmd in idle", 8'(pstate_o), 8'd3);
    sleep_cmd_i = 0; uart_busy_i = 1;
    #1 chk("R9", "uart pending in idle", 8'(uart_clk_en_o), 8'd1);
    gpio_irq_i = 1;
    for (int i = 0; i < SYNC; i++) cyc();
    chk("R8", "still idle", 8'(pstate_o), 8'd3);
    cyc();
    chk("R8", "wake edge", 8'(pstate_o), 8'd5);
    chk("R6", "wake clocks", 8'({stall_o, core_clk_en_o}), 8'b11);
    gpio_irq_i = 0; cyc();
    chk("R6", "back to run", 8'({pstate_o, stall_o}), 8'({3'd0, 1'b0}));
    quiet(SYNC + 1);

    // deep tier ignores timer wake
    sleep_cmd_i = 1; sleep_deep_i = 1; timer_busy_i = 1; cyc();
    sleep_cmd_i = 0; cyc(); cyc();
    chk("R7", "deep", 8'(pstate_o), 8'd4);
    chk("R9", "uart off deep", 8'(uart_clk_en_o), 8'd0);
    chk("R10", "timer off deep", 8'(timer_clk_en_o), 8'd0);
    timer_wake_i = 1;
    for (int i = 0; i < 5; i++) cyc();
    chk("R7", "timer ignored", 8'(pstate_o), 8'd4);
    timer_wake_i = 0; gpio_irq_i = 1;
    for (int i = 0; i <= SYNC; i++) cyc();
    chk("R7", "gpio wakes deep", 8'(pstate_o), 8'd5);
    quiet(SYNC + 2);

    // aborts
    sleep_cmd_i = 1; sleep_deep_i = 0; mem_busy_i = 1; cyc();
    sleep_cmd_i = 0; timer_wake_i = 1; cyc();
    chk("R5", "abort drain", 8'({pstate_o, stall_o}), 8'({3'd0, 1'b0}));
    timer_wake_i = 0; mem_busy_i = 0; sleep_cmd_i = 1; cyc();
    sleep_cmd_i = 0; cyc();
    chk("R5", "in freeze", 8'(pstate_o), 8'd2);
    timer_wake_i = 1; cyc();
    chk("R5", "abort freeze", 8'({pstate_o, stall_o}), 8'({3'd0, 1'b0}));
    quiet(SYNC + 1);

    // random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      sleep_cmd_i  = ($urandom_range(0, 7) == 0);
      sleep_deep_i = $urandom_range(0, 1);
      mem_busy_i   = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 15) == 0) gpio_irq_i = ~gpio_irq_i;
      timer_wake_i = ($urandom_range(0, 19) == 0);
      uart_busy_i  = $urandom_range(0, 1);
      timer_busy_i = $urandom_range(0, 1);
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule